// File: doc/BRIEF.md
# Chip-Select Gated Duplicating Command Register

This block sits between a memory controller and a row of DRAM devices and re-times the command and address bus. It has 22 command/address bits, covering the address, bank address and row/column/write strobes. It also takes two active-low chip selects, two clock-enable bits and two termination-control bits. Every bit is registered on the rising clock edge. Each registered bit leaves the block on two identical copies, named A and B, so that twice the load can be driven.

A static gate-enable input sets how the 22 command bits are sampled. When it is high, the command register loads only on edges where at least one chip select is low. On all other edges it keeps its value, which saves switching on idle cycles. When it is low, the command register loads on every edge. The chip-select, clock-enable and termination bits are never gated.

The block also registers a command-valid strobe, which a downstream parity checker uses. An active-low reset clears every register asynchronously. The registers start sampling again at the first rising edge after reset is released.

Top module: `cmd_dup_register`

## Requirements
- R1: With gate_en high, an edge at which at least one bit of cs_n is 0 loads the command inputs, and they appear on cmd_a and cmd_b after that edge.
- R2: With gate_en high, an edge at which cs_n is 2'b11 leaves cmd_a and cmd_b unchanged, whatever the command inputs are.
- R3: With gate_en low, every rising edge loads the command inputs into cmd_a and cmd_b, whatever the chip selects are.
- R4: The cs_n, cke and odt inputs are registered on every rising edge, whatever gate_en is, and appear on their A and B outputs after that edge.
- R5: Each A output always equals its B output.
- R6: While rst_n is 0, every output, including cmd_valid, is 0. This takes effect at once, without waiting for a clock edge, and it overrides the chip-select control.
- R7: After each edge, cmd_valid is 1 exactly when at least one cs_n bit was 0 at that edge, whatever gate_en is.
- R8: After rst_n rises between edges, the outputs stay 0 until the next rising edge. At that edge they take the sampled inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| gate_en | input | 1 | 1: command bits load only when a chip select is active; 0: they load every edge |
| cmd_in | input | 22 | Command/address inputs (address, bank, strobes) |
| cs_n_in | input | 2 | Active-low chip selects |
| cke_in | input | 2 | Clock-enable inputs |
| odt_in | input | 2 | Termination-control inputs |
| cmd_a | output | 22 | Registered command, copy A |
| cmd_b | output | 22 | Registered command, copy B |
| cs_n_a | output | 2 | Registered chip selects, copy A |
| cs_n_b | output | 2 | Registered chip selects, copy B |
| cke_a | output | 2 | Registered clock enables, copy A |
| cke_b | output | 2 | Registered clock enables, copy B |
| odt_a | output | 2 | Registered termination controls, copy A |
| odt_b | output | 2 | Registered termination controls, copy B |
| cmd_valid | output | 1 | Registered strobe: a chip select was active at the last edge |

## Verification
Several rules are checked by the assertions on every clock edge out of reset: hold on deselected cycles, loading in both gating modes, ungated tracking of the control bits, the valid strobe, equality of the copies, and zero outputs at edges where reset is low. Only the bench scenarios can show two things. First, reset clears the outputs in the middle of a cycle, before any edge arrives. Second, a release between edges keeps the outputs at zero until the following edge. The bench also compares the whole output set against a model under random chip-select and mode patterns.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    parameter int CMD_W  = 22;
    parameter int CS_W   = 2;
    parameter int CKE_W  = 2;
    parameter int ODT_W  = 2;
    parameter int COPIES = 2;

    typedef struct packed {
        logic [CS_W-1:0]  cs_n;
        logic [CKE_W-1:0] cke;
        logic [ODT_W-1:0] odt;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // True when any active-low select is asserted.
    function automatic logic any_selected(input logic [CS_W-1:0] cs_n);
        return ~(&cs_n);
    endfunction

    // Load decision for the gated command register.
    function automatic logic cmd_load(input logic gate_en,
                                      input logic [CS_W-1:0] cs_n);
        return (~gate_en) | any_selected(cs_n);
    endfunction

endpackage

// File: rtl/cmd_gate_reg.sv
module cmd_gate_reg
    import cmdreg_pkg::*;
#(
    parameter int W = CMD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate_en,
    input  logic [CS_W-1:0] cs_n,
    input  logic [W-1:0]    d,
    output logic [W-1:0]    q
);

    logic load;
    assign load = cmd_load(gate_en, cs_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R2: a deselected edge in gated mode keeps the register
    p_hold_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && (&cs_n)) |=> $stable(q));

    // R1: a selected edge in gated mode loads the inputs
    p_load_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !(&cs_n)) |=> (q == $past(d)));

    // R3: ungated mode loads every edge
    p_load_ungated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en) |=> (q == $past(d)));

endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
    import cmdreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t d,
    output ctrl_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R4: control bits follow their inputs on every edge
    p_ctrl_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/cmd_valid_reg.sv
module cmd_valid_reg
    import cmdreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CS_W-1:0] cs_n,
    output logic            valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= any_selected(cs_n);
        end
    end

    // R7: strobe reflects whether a select was active at the prior edge
    p_valid_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (valid == ($past(cs_n) != {CS_W{1'b1}})));

endmodule

// File: rtl/cmd_dup_register.sv
module cmd_dup_register
    import cmdreg_pkg::*;
#(
    parameter int CMD_WIDTH = CMD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gate_en,
    input  logic [CMD_WIDTH-1:0] cmd_in,
    input  logic [CS_W-1:0]      cs_n_in,
    input  logic [CKE_W-1:0]     cke_in,
    input  logic [ODT_W-1:0]     odt_in,
    output logic [CMD_WIDTH-1:0] cmd_a,
    output logic [CMD_WIDTH-1:0] cmd_b,
    output logic [CS_W-1:0]      cs_n_a,
    output logic [CS_W-1:0]      cs_n_b,
    output logic [CKE_W-1:0]     cke_a,
    output logic [CKE_W-1:0]     cke_b,
    output logic [ODT_W-1:0]     odt_a,
    output logic [ODT_W-1:0]     odt_b,
    output logic                 cmd_valid
);

    ctrl_t                ctrl_in;
    logic [CMD_WIDTH-1:0] cmd_q  [COPIES];
    ctrl_t                ctrl_q [COPIES];

    assign ctrl_in = '{cs_n: cs_n_in, cke: cke_in, odt: odt_in};

    // One physical register per output copy.
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        cmd_gate_reg #(.W(CMD_WIDTH)) u_cmd (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate_en (gate_en),
            .cs_n    (cs_n_in),
            .d       (cmd_in),
            .q       (cmd_q[c])
        );

        ctrl_reg u_ctrl (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (ctrl_in),
            .q     (ctrl_q[c])
        );
    end

    cmd_valid_reg u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n_in),
        .valid (cmd_valid)
    );

    assign cmd_a  = cmd_q[0];
    assign cmd_b  = cmd_q[1];
    assign cs_n_a = ctrl_q[0].cs_n;
    assign cs_n_b = ctrl_q[1].cs_n;
    assign cke_a  = ctrl_q[0].cke;
    assign cke_b  = ctrl_q[1].cke;
    assign odt_a  = ctrl_q[0].odt;
    assign odt_b  = ctrl_q[1].odt;

    // R5: the two copies never diverge
    p_copies_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_a == cmd_b) && (ctrl_q[0] == ctrl_q[1]));

    // R6: outputs sit at zero at any edge taken while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r6: assert ((cmd_a == '0) && (cmd_b == '0) &&
                                      (ctrl_q[0] == '0) && (ctrl_q[1] == '0) &&
                                      (cmd_valid == 1'b0));
        end
    end

endmodule

// File: tb/cmd_dup_register_test.sv
`timescale 1ns/1ps
module cmd_dup_register_test;
    import cmdreg_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b1;
    logic             gate_en = 1'b0;
    logic [CMD_W-1:0] cmd_in = '0;
    logic [CS_W-1:0]  cs_n_in = '1;
    logic [CKE_W-1:0] cke_in = '0;
    logic [ODT_W-1:0] odt_in = '0;
    logic [CMD_W-1:0] cmd_a, cmd_b;
    logic [CS_W-1:0]  cs_n_a, cs_n_b;
    logic [CKE_W-1:0] cke_a, cke_b;
    logic [ODT_W-1:0] odt_a, odt_b;
    logic             cmd_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model
    logic [CMD_W-1:0] m_cmd  = '0;
    logic [CS_W-1:0]  m_cs   = '0;
    logic [CKE_W-1:0] m_cke  = '0;
    logic [ODT_W-1:0] m_odt  = '0;
    logic             m_val  = 1'b0;

    cmd_dup_register uut (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cmd_in(cmd_in),
        .cs_n_in(cs_n_in), .cke_in(cke_in), .odt_in(odt_in),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .cs_n_a(cs_n_a), .cs_n_b(cs_n_b),
        .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b),
        .cmd_valid(cmd_valid)
    );

    always #5 clk = ~clk;

    function automatic logic exp_load(logic g, logic [CS_W-1:0] cs);
        return !g || (cs != '1);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " cmd_a"}, 32'(cmd_a), 32'(m_cmd));
        chk("R5 cmd_b", 32'(cmd_b), 32'(cmd_a));
        chk({tag, " cs_n_a R4"}, 32'(cs_n_a), 32'(m_cs));
        chk("R5 cs_n_b", 32'(cs_n_b), 32'(cs_n_a));
        chk({tag, " cke_a R4"}, 32'(cke_a), 32'(m_cke));
        chk("R5 cke_b", 32'(cke_b), 32'(cke_a));
        chk({tag, " odt_a R4"}, 32'(odt_a), 32'(m_odt));
        chk("R5 odt_b", 32'(odt_b), 32'(odt_a));
        chk({tag, " cmd_valid R7"}, 32'(cmd_valid), 32'(m_val));
    endtask

    task automatic chk_zero(string tag);
        chk({tag, " cmd_a"}, 32'(cmd_a), 32'd0);
        chk({tag, " cmd_b"}, 32'(cmd_b), 32'd0);
        chk({tag, " ctrl"}, 32'({cs_n_a, cs_n_b, cke_a, cke_b, odt_a, odt_b}), 32'd0);
        chk({tag, " cmd_valid"}, 32'(cmd_valid), 32'd0);
    endtask

    // Drive at the falling edge, check shortly after the rising edge.
    task automatic cycle(string tag, logic g, logic [CS_W-1:0] cs,
                         logic [CMD_W-1:0] d, logic [CKE_W-1:0] ck,
                         logic [ODT_W-1:0] od);
        @(negedge clk);
        gate_en = g; cs_n_in = cs; cmd_in = d; cke_in = ck; odt_in = od;
        @(posedge clk);
        #2;
        if (rst_n) begin
            if (exp_load(g, cs)) m_cmd = d;
            m_cs  = cs;
            m_cke = ck;
            m_odt = od;
            m_val = (cs != '1);
        end
        chk_all(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        #2 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 chk_zero("R6 reset");
        @(negedge clk);
        gate_en = 1'b1; cs_n_in = 2'b11; cmd_in = 22'h3ABCDE;
        cke_in = 2'b11; odt_in = 2'b10;
        #2 rst_n = 1'b1;
        #1 chk_zero("R8 before edge");
        @(posedge clk);
        #2;
        m_cs = 2'b11; m_cke = 2'b11; m_odt = 2'b10; m_val = 1'b0;
        chk_all("R8 first edge");   // deselected gated: cmd stays 0

        // R1: selected edges in gated mode
        cycle("R1 cs0", 1'b1, 2'b10, 22'h155555, 2'b01, 2'b01);
        cycle("R1 cs1", 1'b1, 2'b01, 22'h2AAAAA, 2'b10, 2'b00);
        cycle("R1 both", 1'b1, 2'b00, 22'h3FFFFF, 2'b11, 2'b11);
        // R2: deselected edges hold
        cycle("R2 hold", 1'b1, 2'b11, 22'h000001, 2'b00, 2'b01);
        cycle("R2 hold", 1'b1, 2'b11, 22'h123456, 2'b01, 2'b10);
        // R3: ungated mode loads with no select
        cycle("R3 ungated", 1'b0, 2'b11, 22'h0F0F0F, 2'b10, 2'b11);
        cycle("R3 ungated", 1'b0, 2'b11, 22'h000000, 2'b00, 2'b00);
        cycle("R3 ungated", 1'b0, 2'b01, 22'h3C3C3C, 2'b11, 2'b01);
        // R2 again after mode switch back
        cycle("R2 after switch", 1'b1, 2'b11, 22'h111111, 2'b01, 2'b01);

        for (int i = 0; i < 600; i++) begin
            logic g;
            logic [CS_W-1:0] cs;
            g  = ($urandom % 4) != 0;
            cs = (($urandom % 3) == 0) ? 2'b11 : CS_W'($urandom);
            cycle("R1/R2/R3 random", g, cs, CMD_W'($urandom),
                  CKE_W'($urandom), ODT_W'($urandom));
        end

        // R6: mid-cycle reset clears before any edge
        cycle("R1 preload", 1'b0, 2'b00, 22'h3FFFFF, 2'b11, 2'b11);
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1 chk_zero("R6 async");
        @(posedge clk);
        #2 chk_zero("R6 edge in reset");
        m_cmd = '0; m_cs = '0; m_cke = '0; m_odt = '0; m_val = 1'b0;
        // R8: release between edges, first update at next edge
        @(negedge clk);
        gate_en = 1'b1; cs_n_in = 2'b10; cmd_in = 22'h2DCBA9;
        cke_in = 2'b01; odt_in = 2'b11;
        #1 rst_n = 1'b1;
        #1 chk_zero("R8 released, no edge");
        @(posedge clk);
        #2;
        m_cmd = 22'h2DCBA9; m_cs = 2'b10; m_cke = 2'b01; m_odt = 2'b11; m_val = 1'b1;
        chk_all("R8 first edge load");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule